// File: doc/BRIEF.md
# Packet Transmit Bus Sink

This block sits on the receiving (PHY) side of a packet transmit bus. Each cycle it takes a data word and the per-lane control signals that travel with it. These are a write enable, start and end markers, an error flag, a parity bit and a byte-count field. The block turns them into qualified per-channel outputs. A mode input sets the shape of the bus. In wide mode the bus is one 32-bit channel, and lane 0's controls and parity bit cover the whole word. In narrow mode it is four independent 8-bit channels, and each channel has its own controls and parity.

Every input passes through one register stage before it is examined, so each output belongs to the input cycle one clock earlier. A marker is only honoured when the write enable of its lane (active-low at the pins) is asserted. Parity is checked in any cycle where the enable or the port-select strobe of that lane is active. The expected polarity is odd, or even when selected. For each channel the block follows packet boundaries and pulses a framing error on a misplaced word. It also keeps a sticky parity status per channel, which a clear input resets.

Top module: `pos_tx_sink`

## Requirements
- R1: Every output appears exactly one clock after the input cycle it belongs to. For each lane, `out_vld` is high exactly when that lane's active-low `wen_n` bit was low, with lane 0 used in wide mode.
- R2: With `cfg_wide`=1, lane 0's enable and markers qualify the whole 32-bit word. Lanes 1 to 3 then show no valid, marker, error or parity activity, and their packet state is left untouched. With `cfg_wide`=0, each lane's controls act only on its own byte, where lane n is bits [8n+7:8n]. `out_dat` always shows the captured bus.
- R3: `out_perr[n]` pulses when lane n's enable or `psel[n]` is active and the parity is wrong. With `cfg_even`=0, data plus parity bit must hold an odd number of ones; with `cfg_even`=1, an even number. In wide mode, `tx_par[0]` covers all 32 bits and the result is reported on bit 0. In narrow mode, `tx_par[n]` covers lane n.
- R4: `out_sop` and `out_eop` are raised only for words whose lane enable was asserted.
- R5: `out_err` is raised only when the error flag came with end-of-packet and an asserted enable.
- R6: In wide mode, `out_mod` carries `tx_mod` (the count of valid bytes, where 0 means all four) on an end-of-packet word. It is 0 otherwise, and always 0 in narrow mode.
- R7: `out_frm[n]` pulses for an enabled word that arrives outside a packet without a start marker, or that carries a start marker while a packet is open. A word with both start and end markers is a complete packet.
- R8: `out_perr_hold[n]` is set in the clock after a parity pulse. It is cleared by `perr_clr` one clock after `perr_clr` is sampled. A new parity pulse wins over a clear in the same cycle.
- R9: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1: one 32-bit channel; 0: four 8-bit channels |
| cfg_even | input | 1 | 1: even parity expected; 0: odd |
| wen_n | input | 4 | Per-lane write enable, active-low |
| psel | input | 4 | Per-lane port-select strobe (qualifies parity only) |
| tx_dat | input | 32 | Data bus |
| tx_sop | input | 4 | Per-lane start-of-packet |
| tx_eop | input | 4 | Per-lane end-of-packet |
| tx_err | input | 4 | Per-lane packet error |
| tx_par | input | 4 | Per-lane parity bit |
| tx_mod | input | 2 | Valid-byte count on the last wide word |
| perr_clr | input | 1 | Clears the sticky parity status |
| out_dat | output | 32 | Captured data |
| out_vld | output | 4 | Per-channel word valid |
| out_sop | output | 4 | Qualified start marker |
| out_eop | output | 4 | Qualified end marker |
| out_err | output | 4 | Qualified packet error |
| out_mod | output | 2 | Valid-byte count on wide end word |
| out_perr | output | 4 | Parity error pulse |
| out_perr_hold | output | 4 | Sticky parity error |
| out_frm | output | 4 | Framing error pulse |

## Verification
A parity failure and a framing violation can land on the same channel in the same cycle. Both pulses must appear together, and the sticky bit must follow one clock later. The bench provokes this with a badly-parity'd word on a lane that has an open packet and carries a second start marker. The same happens with a stray word outside any packet. A parity pulse can also meet a clear request in the same cycle, and the sticky bit must then stay set. The scoreboard predicts every output field from its own model of the packet state, parity and sticky bits, and compares each field on the clock the output belongs to.

// File: rtl/pos_sink_pkg.sv
package pos_sink_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int BUS_W  = LANES * LANE_W;
  localparam int MOD_W  = $clog2(LANES);

  typedef struct packed {
    logic             wide;
    logic             even;
    logic [LANES-1:0] vld;
    logic [LANES-1:0] qual;
    logic [LANES-1:0] sop;
    logic [LANES-1:0] eop;
    logic [LANES-1:0] err;
    logic [LANES-1:0] par;
    logic [MOD_W-1:0] mod;
    logic [BUS_W-1:0] dat;
  } stage_t;
endpackage

// File: rtl/pos_sink_capture.sv
module pos_sink_capture
  import pos_sink_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  stage_t d,
  output stage_t q
);
  stage_t q_nxt;

  always_comb q_nxt = d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/pos_sink_parity.sv
module pos_sink_parity #(
  parameter int W = 8
) (
  input  logic         even,
  input  logic         qual,
  input  logic [W-1:0] dat,
  input  logic         par,
  output logic         err
);
  logic ones_odd;

  always_comb begin
    ones_odd = ^{dat, par};
    err      = qual & (even ? ones_odd : ~ones_odd);
  end
endmodule

// File: rtl/pos_sink_frame.sv
module pos_sink_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic sop,
  input  logic eop,
  output logic frm_err
);
  logic open_q, open_d;

  always_comb begin
    open_d = open_q;
    if (vld) open_d = (open_q | sop) & ~eop;
    // stray word when closed without sop, or sop while open
    frm_err = vld & (open_q == sop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end
endmodule

// File: rtl/pos_tx_sink.sv
module pos_tx_sink
  import pos_sink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic             cfg_even,
  input  logic [LANES-1:0] wen_n,
  input  logic [LANES-1:0] psel,
  input  logic [BUS_W-1:0] tx_dat,
  input  logic [LANES-1:0] tx_sop,
  input  logic [LANES-1:0] tx_eop,
  input  logic [LANES-1:0] tx_err,
  input  logic [LANES-1:0] tx_par,
  input  logic [MOD_W-1:0] tx_mod,
  input  logic             perr_clr,
  output logic [BUS_W-1:0] out_dat,
  output logic [LANES-1:0] out_vld,
  output logic [LANES-1:0] out_sop,
  output logic [LANES-1:0] out_eop,
  output logic [LANES-1:0] out_err,
  output logic [MOD_W-1:0] out_mod,
  output logic [LANES-1:0] out_perr,
  output logic [LANES-1:0] out_perr_hold,
  output logic [LANES-1:0] out_frm
);
  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int = rsync_q[1];

  // input stage
  stage_t cap_d, st;

  always_comb begin
    cap_d.wide = cfg_wide;
    cap_d.even = cfg_even;
    cap_d.vld  = ~wen_n;
    cap_d.qual = ~wen_n | psel;
    cap_d.sop  = tx_sop;
    cap_d.eop  = tx_eop;
    cap_d.err  = tx_err;
    cap_d.par  = tx_par;
    cap_d.mod  = tx_mod;
    cap_d.dat  = tx_dat;
  end

  pos_sink_capture u_cap (.clk(clk), .rst_n(rst_int), .d(cap_d), .q(st));

  // parity domains
  logic             perr_wide;
  logic [LANES-1:0] perr_lane;

  pos_sink_parity #(.W(BUS_W)) u_par_wide (
    .even(st.even), .qual(st.qual[0]), .dat(st.dat), .par(st.par[0]),
    .err(perr_wide)
  );

  // per-channel qualification
  logic [LANES-1:0] ch_vld, ch_sop, ch_eop, ch_err, ch_perr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pos_sink_parity #(.W(LANE_W)) u_par (
      .even(st.even), .qual(st.qual[g]),
      .dat(st.dat[g*LANE_W +: LANE_W]), .par(st.par[g]),
      .err(perr_lane[g])
    );

    if (g == 0) begin : g_head
      assign ch_vld[g]  = st.vld[g];
      assign ch_perr[g] = st.wide ? perr_wide : perr_lane[g];
    end else begin : g_tail
      assign ch_vld[g]  = st.vld[g] & ~st.wide;
      assign ch_perr[g] = perr_lane[g] & ~st.wide;
    end

    assign ch_sop[g] = ch_vld[g] & st.sop[g];
    assign ch_eop[g] = ch_vld[g] & st.eop[g];
    assign ch_err[g] = ch_eop[g] & st.err[g];

    pos_sink_frame u_frm (
      .clk(clk), .rst_n(rst_int), .vld(ch_vld[g]),
      .sop(st.sop[g]), .eop(st.eop[g]), .frm_err(out_frm[g])
    );
  end

  always_comb begin
    out_dat  = st.dat;
    out_vld  = ch_vld;
    out_sop  = ch_sop;
    out_eop  = ch_eop;
    out_err  = ch_err;
    out_perr = ch_perr;
    out_mod  = (st.wide & ch_eop[0]) ? st.mod : '0;
  end

  // sticky parity status, set dominates clear
  logic [LANES-1:0] hold_q, hold_d;

  always_comb hold_d = (hold_q & ~{LANES{perr_clr}}) | ch_perr;

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) hold_q <= '0;
    else          hold_q <= hold_d;
  end

  assign out_perr_hold = hold_q;
endmodule

// File: rtl/pos_tx_sink_chk.sv
module pos_tx_sink_chk
  import pos_sink_pkg::*;
(
  input logic             clk,
  input logic             rst_int,
  input logic             cfg_wide,
  input logic [LANES-1:0] wen_n,
  input logic [LANES-1:0] out_vld,
  input logic [LANES-1:0] out_sop,
  input logic [LANES-1:0] out_eop,
  input logic [LANES-1:0] out_err,
  input logic [MOD_W-1:0] out_mod,
  input logic [LANES-1:0] out_perr,
  input logic [LANES-1:0] out_perr_hold,
  input logic [LANES-1:0] out_frm
);
  // R1
  lane0_take_chk: assert property (@(posedge clk) disable iff (!rst_int)
    !wen_n[0] |=> out_vld[0]);
  // R1
  lane0_idle_chk: assert property (@(posedge clk) disable iff (!rst_int)
    wen_n[0] |=> !out_vld[0]);
  // R2
  wide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int)
    cfg_wide |=> ((out_vld | out_perr) & ~LANES'(1)) == '0);
  // R4
  marker_qual_chk: assert property (@(posedge clk) disable iff (!rst_int)
    ((out_sop | out_eop) & ~out_vld) == '0);
  // R5
  err_qual_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (out_err & ~out_eop) == '0);
  // R6
  mod_eop_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (out_mod != '0) |-> out_eop[0]);
  // R7
  frm_vld_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (out_frm & ~out_vld) == '0);
  // R8
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (out_perr != '0) |=> ((out_perr_hold & $past(out_perr)) == $past(out_perr)));
endmodule

bind pos_tx_sink pos_tx_sink_chk u_chk (
  .clk(clk), .rst_int(rst_int), .cfg_wide(cfg_wide), .wen_n(wen_n),
  .out_vld(out_vld), .out_sop(out_sop), .out_eop(out_eop),
  .out_err(out_err), .out_mod(out_mod), .out_perr(out_perr),
  .out_perr_hold(out_perr_hold), .out_frm(out_frm)
);

// File: tb/sim_pos_tx_sink.sv
`timescale 1ns/1ps
module sim_pos_tx_sink;
  logic        clk, rst_n;
  logic        cfg_wide, cfg_even, perr_clr;
  logic [3:0]  wen_n, psel, tx_sop, tx_eop, tx_err, tx_par;
  logic [31:0] tx_dat;
  logic [1:0]  tx_mod;
  logic [31:0] out_dat;
  logic [3:0]  out_vld, out_sop, out_eop, out_err, out_perr, out_perr_hold, out_frm;
  logic [1:0]  out_mod;

  pos_tx_sink u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [3:0] vld, sop, eop, err, perr, frm;
    logic [1:0] mod;
    logic [31:0] dat;
    logic clr;
  } exp_t;

  exp_t exp_q[$];
  logic [3:0] mdl_open = 4'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic odd_ones(input logic [31:0] v);
    return logic'($countones(v) % 2);
  endfunction

  // parity bit that makes the word correct
  function automatic logic [3:0] good_par(input logic w, input logic ev, input logic [31:0] d);
    logic [3:0] p;
    if (w) p = {3'b000, ev ? odd_ones(d) : ~odd_ones(d)};
    else
      for (int n = 0; n < 4; n++)
        p[n] = ev ? odd_ones({24'd0, d[n*8 +: 8]}) : ~odd_ones({24'd0, d[n*8 +: 8]});
    return p;
  endfunction

  task automatic drv(input logic w, input logic ev, input logic [3:0] wn, input logic [3:0] ps,
                     input logic [31:0] d, input logic [3:0] s, input logic [3:0] e,
                     input logic [3:0] er, input logic [3:0] p, input logic [1:0] m,
                     input logic clr);
    exp_t x;
    @(negedge clk);
    cfg_wide = w; cfg_even = ev; wen_n = wn; psel = ps; tx_dat = d;
    tx_sop = s; tx_eop = e; tx_err = er; tx_par = p; tx_mod = m; perr_clr = clr;
    x.vld = '0; x.sop = '0; x.eop = '0; x.err = '0; x.perr = '0; x.frm = '0;
    x.mod = '0; x.dat = d; x.clr = clr;
    for (int n = 0; n < 4; n++) begin
      logic v, q, ones;
      if (w && n != 0) continue;
      v = ~wn[n];
      q = v | ps[n];
      ones = w ? odd_ones(d ^ {31'd0, 1'b0}) ^ p[0] : odd_ones({24'd0, d[n*8 +: 8]}) ^ p[n];
      x.vld[n]  = v;
      x.sop[n]  = v & s[n];
      x.eop[n]  = v & e[n];
      x.err[n]  = v & e[n] & er[n];
      x.perr[n] = q & (ev ? ones : ~ones);
      x.frm[n]  = v & (mdl_open[n] ? s[n] : ~s[n]);
      if (v) mdl_open[n] = (mdl_open[n] | s[n]) & ~e[n];
    end
    if (w && x.eop[0]) x.mod = m;
    exp_q.push_back(x);
  endtask

  task automatic idle(input logic clr);
    drv(1'b0, 1'b0, 4'hF, 4'h0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 2'd0, clr);
  endtask

  // scoreboard monitor
  logic [3:0] prev_hold = 4'b0;
  logic [3:0] prev_perr = 4'b0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t x;
        logic [3:0] eh;
        x = exp_q.pop_front();
        chk("R1 out_vld", {28'd0, out_vld}, {28'd0, x.vld});
        chk("R2 out_dat", out_dat, x.dat);
        chk("R4 out_sop", {28'd0, out_sop}, {28'd0, x.sop});
        chk("R4 out_eop", {28'd0, out_eop}, {28'd0, x.eop});
        chk("R5 out_err", {28'd0, out_err}, {28'd0, x.err});
        chk("R3 out_perr", {28'd0, out_perr}, {28'd0, x.perr});
        chk("R7 out_frm", {28'd0, out_frm}, {28'd0, x.frm});
        chk("R6 out_mod", {30'd0, out_mod}, {30'd0, x.mod});
        eh = (prev_hold & ~{4{x.clr}}) | prev_perr;
        chk("R8 out_perr_hold", {28'd0, out_perr_hold}, {28'd0, eh});
        prev_hold = eh;
        prev_perr = x.perr;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, r;
    rst_n = 1'b0;
    cfg_wide = 0; cfg_even = 0; wen_n = 4'b0000; psel = 4'hF; tx_dat = 32'hFFFF_FFFF;
    tx_sop = 4'hF; tx_eop = 4'hF; tx_err = 4'hF; tx_par = 4'h0; tx_mod = 2'd3; perr_clr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state under active inputs
    chk("R9 out_vld reset", {28'd0, out_vld}, 32'd0);
    chk("R9 out_dat reset", out_dat, 32'd0);
    chk("R9 out_perr reset", {28'd0, out_perr | out_perr_hold}, 32'd0);
    chk("R9 out_frm/mod reset", {26'd0, out_frm, out_mod}, 32'd0);
    wen_n = 4'hF; psel = 4'h0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R4 narrow: three-word packet on lane 0, odd parity
    d = 32'h0000_0011; drv(0, 0, 4'b1110, 0, d, 4'b0001, 0, 0, good_par(0, 0, d), 0, 0);
    d = 32'h0000_0023; drv(0, 0, 4'b1110, 0, d, 0, 0, 0, good_par(0, 0, d), 0, 0);
    d = 32'h0000_0007; drv(0, 0, 4'b1110, 0, d, 0, 4'b0001, 0, good_par(0, 0, d), 0, 0);
    // R2 R5 four single-word packets, lane 2 with error
    d = 32'hA1B2_C3D4; drv(0, 0, 4'b0000, 0, d, 4'hF, 4'hF, 4'b0100, good_par(0, 0, d), 2'd1, 0);
    // R3 bad parity lane1 with enable, psel-only bad parity lane3
    d = 32'h5500_3300;
    drv(0, 0, 4'b1101, 4'b1000, d, 4'b0010, 4'b0010, 0, good_par(0, 0, d) ^ 4'b1010, 0, 0);
    idle(0);
    // R8 clear
    idle(1);
    idle(0);
    // R5 err without eop ignored; R4 markers without enable ignored
    d = 32'h0000_0100; drv(0, 0, 4'b1101, 0, d, 4'b0010, 0, 4'b0010, good_par(0, 0, d), 0, 0);
    drv(0, 0, 4'b1111, 0, 32'h0, 4'hF, 4'hF, 4'hF, 4'h0, 0, 0);
    d = 32'h0000_0200; drv(0, 0, 4'b1101, 0, d, 0, 4'b0010, 0, good_par(0, 0, d), 0, 0);
    // R7 stray word lane2, double sop lane1
    d = 32'h0042_0000; drv(0, 0, 4'b1011, 0, d, 0, 0, 0, good_par(0, 0, d), 0, 0);
    d = 32'h0000_0100; drv(0, 0, 4'b1101, 0, d, 4'b0010, 0, 0, good_par(0, 0, d), 0, 0);
    // R3 R7 parity and framing together on lane1 (second sop), clear colliding (R8)
    d = 32'h0000_0300; drv(0, 0, 4'b1101, 0, d, 4'b0010, 4'b0010, 0, good_par(0, 0, d) ^ 4'b0010, 0, 1);
    idle(1);
    idle(0);
    // R2 R6 wide odd: packet with bad middle word, lanes 1-3 enables ignored
    d = 32'h1234_5678; drv(1, 0, 4'b0000, 0, d, 4'b1111, 0, 4'hF, good_par(1, 0, d), 2'd2, 0);
    d = 32'h0F0F_0F0F; drv(1, 0, 4'b0000, 4'b1110, d, 0, 4'hE, 0, good_par(1, 0, d) ^ 4'b1111, 2'd3, 0);
    d = 32'hDEAD_BEEF; drv(1, 0, 4'b1110, 0, d, 0, 4'b0001, 4'b0001, good_par(1, 0, d), 2'd2, 0);
    // R3 wide even, good then bad; R6 mod 0 on eop word
    d = 32'h8000_0001; drv(1, 1, 4'b1110, 0, d, 4'b0001, 4'b0001, 0, good_par(1, 1, d), 2'd0, 0);
    d = 32'h8000_0003; drv(1, 1, 4'b1110, 0, d, 4'b0001, 4'b0001, 0, good_par(1, 1, d) ^ 4'b0001, 2'd1, 0);
    // R3 narrow even parity
    d = 32'h0103_0701; drv(0, 1, 4'b0000, 0, d, 4'hF, 4'hF, 0, good_par(0, 1, d) ^ 4'b0100, 0, 0);
    idle(1);
    // mixed pseudo-random traffic
    r = 32'hC0FF_EE01;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      r = r * 32'd1664525 + 32'd1013904223; a = r;
      r = r * 32'd1664525 + 32'd1013904223; b = r;
      drv(b[31] & b[30], b[29], b[3:0] & b[7:4], b[11:8] & b[15:12], a,
          b[19:16], b[23:20], b[27:24],
          good_par(b[31] & b[30], b[29], a) ^ (b[28] ? {b[1:0], b[5:4]} : 4'h0),
          b[9:8], b[26] & b[25]);
    end
    idle(0);
    idle(0);
    @(posedge clk); #2;
    chk("R1 scoreboard drained", exp_q.size(), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule